// File: doc/BRIEF.md
# Indirect Table Access Port

This block reaches a family of internal lookup tables through two 64-bit registers. An address register names a table, an entry within it and whether the entry pointer steps forward after each access. A data register then reads or writes that entry. Each table has its own index wrap, and only some tables have storage here. The rest decode as valid but read as zero and drop writes. Software can sweep a whole table by setting the step bit once and issuing back-to-back data accesses.

Side effects leave the block as one-cycle pulses. Every data write to a known table announces the table and entry. A write to the window table asks for that one window to be recomputed. A write to the interrupt-vector table is reduced to its three meaningful fields and passes on the target server with its two link-pointer bits removed. Address bits outside the decoded fields are kept exactly as written.

Top module: `table_access_port`

## Requirements
- R1: After reset the address register reads as 0. A read of the address register (`acc_data_sel`=0) returns all 64 bits exactly as last written.
- R2: The table select is address bits 51:48, the entry index is bits 8:0 and the step bit is bit 63. The index is ANDed with the table's mask before use. The select codes and masks are: 0 list (7), 1 interrupt vector (7), 2 vector cache (31), 3 reorder buffer (31), 4 requester cache (63), 5 mapping (7), 6 state A (255), 7 state B (255), 8 translation (511), 9 translation cache (63), 10 translation data (63), 11 window (15), 12 segment (255), 13 event (3).
- R3: A data access to a known table with the step bit set writes (index+1) AND mask into address bits 8:0 and leaves all other bits unchanged. With the step bit clear, the address register does not change.
- R4: Codes 2, 3, 4, 5, 6, 7, 9 and 10 have no storage. A data read returns 0 and a data write is dropped, but the index still steps.
- R5: Codes 14 and 15 are unknown. A data access raises `acc_err` for one cycle, returns 0 on a read, writes nothing, raises no change pulse and leaves the address register unchanged.
- R6: A write to the interrupt-vector table keeps only server bits 31:24, priority bits 23:16 and node bits 3:0, and stores zero in every other bit.
- R7: One cycle after an interrupt-vector write, `irq_cfg_valid` pulses with the entry index, `irq_server` = written bits 31:26 (server shifted right by 2) and `irq_prio` = written bits 23:16.
- R8: One cycle after a window-table write, `win_update` pulses with the masked entry index.
- R9: One cycle after any data write to a known table, `chg_valid` pulses with the table code and the masked index.
- R10: Every read access raises `acc_rvalid` with `acc_rdata` exactly one cycle later. Write accesses raise no `acc_rvalid`.
- R11: Tables 0, 1, 8, 11, 12 and 13 have storage. A data read returns the last value stored at that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_data_sel | input | 1 | 0 = address register, 1 = data register |
| acc_wdata | input | 64 | Write data |
| acc_rvalid | output | 1 | Read data valid |
| acc_rdata | output | 64 | Read data |
| acc_err | output | 1 | Data access to an unknown table |
| chg_valid | output | 1 | Data write to a known table |
| chg_table | output | 4 | Table code of that write |
| chg_index | output | 9 | Masked entry index of that write |
| win_update | output | 1 | Window entry rewritten |
| win_index | output | 4 | Window entry index |
| irq_cfg_valid | output | 1 | Interrupt-vector entry rewritten |
| irq_cfg_index | output | 3 | Interrupt-vector entry index |
| irq_server | output | 6 | Server number, link bits removed |
| irq_prio | output | 8 | Priority |

## Verification
All results appear one cycle after the access that causes them: the read data and its valid flag, the error flag, the three pulses, and the new address register contents. The bench drives each access on a falling edge and samples at the next falling edge, one rising edge later. Each access therefore shows only its own pulses, and a pulse that stayed high too long shows up as a mismatch on the following access. The stepped index is checked by reading the address register back in a later access.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int unsigned DATA_W    = 64;
    localparam int unsigned SEL_W     = 4;
    localparam int unsigned SEL_LSB   = 48;
    localparam int unsigned IDX_W     = 9;
    localparam int unsigned IDX_LSB   = 0;
    localparam int unsigned AINC_BIT  = 63;
    localparam int unsigned NUM_SEL   = 1 << SEL_W;

    // interrupt-vector entry fields
    localparam int unsigned SRV_LSB   = 24;
    localparam int unsigned SRV_W     = 8;
    localparam int unsigned PRI_LSB   = 16;
    localparam int unsigned PRI_W     = 8;
    localparam int unsigned NODE_LSB  = 0;
    localparam int unsigned NODE_W    = 4;
    localparam int unsigned LINK_W    = 2;
    localparam int unsigned IRQ_SRV_W = SRV_W - LINK_W;

    localparam int unsigned WIN_IDX_W = 4;
    localparam int unsigned IVT_IDX_W = 3;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [SEL_W-1:0] {
        TB_LIST  = 4'd0,
        TB_IVT   = 4'd1,
        TB_VCAM  = 4'd2,
        TB_ROB   = 4'd3,
        TB_RQC   = 4'd4,
        TB_MAP   = 4'd5,
        TB_STA   = 4'd6,
        TB_STB   = 4'd7,
        TB_XLAT  = 4'd8,
        TB_XCAM  = 4'd9,
        TB_XDAT  = 4'd10,
        TB_WIN   = 4'd11,
        TB_SEG   = 4'd12,
        TB_EVT   = 4'd13
    } tbl_e;

    typedef struct packed {
        logic known;
        logic backed;
        logic ainc;
        sel_t sel;
        idx_t mask;
        idx_t idx;
        idx_t nxt;
    } dec_t;

    function automatic idx_t tbl_mask(input sel_t s);
        case (s)
            TB_LIST, TB_IVT, TB_MAP:  return idx_t'(7);
            TB_VCAM, TB_ROB:          return idx_t'(31);
            TB_RQC, TB_XCAM, TB_XDAT: return idx_t'(63);
            TB_STA, TB_STB, TB_SEG:   return idx_t'(255);
            TB_XLAT:                  return idx_t'(511);
            TB_WIN:                   return idx_t'(15);
            TB_EVT:                   return idx_t'(3);
            default:                  return '0;
        endcase
    endfunction

    function automatic logic tbl_known(input sel_t s);
        return s <= TB_EVT;
    endfunction

    function automatic logic tbl_backed(input sel_t s);
        case (s)
            TB_LIST, TB_IVT, TB_XLAT, TB_WIN, TB_SEG, TB_EVT: return 1'b1;
            default:                                          return 1'b0;
        endcase
    endfunction

    function automatic int unsigned tbl_depth(input sel_t s);
        return int'(tbl_mask(s)) + 1;
    endfunction

    function automatic word_t ivt_keep_mask();
        word_t m;
        m = '0;
        m[SRV_LSB  +: SRV_W]  = '1;
        m[PRI_LSB  +: PRI_W]  = '1;
        m[NODE_LSB +: NODE_W] = '1;
        return m;
    endfunction

    localparam word_t IVT_KEEP = ivt_keep_mask();

endpackage

// File: rtl/tap_decode.sv
module tap_decode
    import tap_pkg::*;
(
    input  sel_t sel,
    input  idx_t raw_idx,
    input  logic ainc,
    output dec_t dec
);
    idx_t mask;

    always_comb begin
        mask       = tbl_mask(sel);
        dec.known  = tbl_known(sel);
        dec.backed = tbl_backed(sel);
        dec.ainc   = ainc;
        dec.sel    = sel;
        dec.mask   = mask;
        dec.idx    = raw_idx & mask;
        dec.nxt    = (dec.idx + idx_t'(1)) & mask;
    end

endmodule

// File: rtl/tap_addr_reg.sv
module tap_addr_reg
    import tap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_val,
    input  logic  step,
    input  idx_t  step_idx,
    output word_t addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step) begin
            addr_q[IDX_LSB +: IDX_W] <= step_idx;
        end
    end

endmodule

// File: rtl/tap_store.sv
module tap_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 64,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/tap_bank.sv
module tap_bank
    import tap_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  sel_t  sel,
    input  idx_t  idx,
    input  word_t wdata,
    output word_t rdata
);
    word_t rd_arr [NUM_SEL];

    for (genvar t = 0; t < NUM_SEL; t++) begin : g_tbl
        if (tbl_backed(SEL_W'(t))) begin : g_mem
            localparam int unsigned DEPTH = tbl_depth(SEL_W'(t));
            localparam int unsigned AW    = $clog2(DEPTH);
            tap_store #(
                .DEPTH (DEPTH),
                .DW    (DATA_W)
            ) u_store (
                .clk   (clk),
                .we    (we && (sel == SEL_W'(t))),
                .addr  (idx[AW-1:0]),
                .wdata (wdata),
                .rdata (rd_arr[t])
            );
        end else begin : g_none
            assign rd_arr[t] = '0;
        end
    end

    assign rdata = rd_arr[sel];

endmodule

// File: rtl/table_access_port.sv
module table_access_port
    import tap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic                 acc_data_sel,
    input  logic [DATA_W-1:0]    acc_wdata,
    output logic                 acc_rvalid,
    output logic [DATA_W-1:0]    acc_rdata,
    output logic                 acc_err,
    output logic                 chg_valid,
    output logic [SEL_W-1:0]     chg_table,
    output logic [IDX_W-1:0]     chg_index,
    output logic                 win_update,
    output logic [WIN_IDX_W-1:0] win_index,
    output logic                 irq_cfg_valid,
    output logic [IVT_IDX_W-1:0] irq_cfg_index,
    output logic [IRQ_SRV_W-1:0] irq_server,
    output logic [PRI_W-1:0]     irq_prio
);
    word_t addr_q;
    dec_t  dec;
    word_t bank_rd;
    word_t wdata_filt;
    logic  data_acc, wr_data, rd_data, step, bank_we, is_ivt, is_win;

    tap_decode u_dec (
        .sel     (addr_q[SEL_LSB +: SEL_W]),
        .raw_idx (addr_q[IDX_LSB +: IDX_W]),
        .ainc    (addr_q[AINC_BIT]),
        .dec     (dec)
    );

    assign data_acc   = acc_valid && acc_data_sel;
    assign wr_data    = data_acc && acc_write;
    assign rd_data    = data_acc && !acc_write;
    assign step       = data_acc && dec.known && dec.ainc;
    assign is_ivt     = (dec.sel == TB_IVT);
    assign is_win     = (dec.sel == TB_WIN);
    assign bank_we    = wr_data && dec.known && dec.backed;
    assign wdata_filt = is_ivt ? (acc_wdata & IVT_KEEP) : acc_wdata;

    tap_addr_reg u_areg (
        .clk      (clk),
        .rst      (rst),
        .load     (acc_valid && !acc_data_sel && acc_write),
        .load_val (acc_wdata),
        .step     (step),
        .step_idx (dec.nxt),
        .addr_q   (addr_q)
    );

    tap_bank u_bank (
        .clk   (clk),
        .we    (bank_we),
        .sel   (dec.sel),
        .idx   (dec.idx),
        .wdata (wdata_filt),
        .rdata (bank_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_rvalid    <= 1'b0;
            acc_rdata     <= '0;
            acc_err       <= 1'b0;
            chg_valid     <= 1'b0;
            chg_table     <= '0;
            chg_index     <= '0;
            win_update    <= 1'b0;
            win_index     <= '0;
            irq_cfg_valid <= 1'b0;
            irq_cfg_index <= '0;
            irq_server    <= '0;
            irq_prio      <= '0;
        end else begin
            acc_rvalid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write) begin
                if (!acc_data_sel) begin
                    acc_rdata <= addr_q;
                end else begin
                    acc_rdata <= dec.known ? bank_rd : '0;
                end
            end
            acc_err       <= data_acc && !dec.known;
            chg_valid     <= wr_data && dec.known;
            chg_table     <= dec.sel;
            chg_index     <= dec.idx;
            win_update    <= wr_data && dec.known && is_win;
            win_index     <= dec.idx[WIN_IDX_W-1:0];
            irq_cfg_valid <= wr_data && dec.known && is_ivt;
            irq_cfg_index <= dec.idx[IVT_IDX_W-1:0];
            irq_server    <= wdata_filt[SRV_LSB + LINK_W +: IRQ_SRV_W];
            irq_prio      <= wdata_filt[PRI_LSB +: PRI_W];
        end
    end

    // R3: stepped index wraps inside the table
    a_r3_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (data_acc && dec.known && dec.ainc) |=>
        (addr_q[IDX_LSB +: IDX_W] == (($past(dec.idx) + idx_t'(1)) & $past(dec.mask))));

    a_r3_no_step_hold: assert property (@(posedge clk) disable iff (rst)
        (data_acc && dec.known && !dec.ainc) |=> $stable(addr_q));

    a_r5_unknown_inert: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !dec.known) |=> ($stable(addr_q) && acc_err && !chg_valid));

    a_r4_unbacked_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data && dec.known && !dec.backed) |=> (acc_rdata == '0));

    a_r6_ivt_clean: assert property (@(posedge clk) disable iff (rst)
        (rd_data && is_ivt) |=> ((acc_rdata & ~IVT_KEEP) == '0));

    a_r9_chg_cause: assert property (@(posedge clk) disable iff (rst)
        chg_valid |-> $past(wr_data && dec.known));

    a_r8_win_pulse: assert property (@(posedge clk) disable iff (rst)
        win_update |-> (chg_valid && (chg_table == TB_WIN)));

    a_r7_irq_server: assert property (@(posedge clk) disable iff (rst)
        irq_cfg_valid |-> (irq_server == $past(acc_wdata[SRV_LSB + LINK_W +: IRQ_SRV_W])));

    a_r10_rvalid: assert property (@(posedge clk) disable iff (rst)
        acc_rvalid |-> $past(acc_valid && !acc_write));

endmodule

// File: tb/table_access_port_test.sv
module table_access_port_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_write, acc_data_sel;
    logic [63:0] acc_wdata;
    logic        acc_rvalid, acc_err, chg_valid, win_update, irq_cfg_valid;
    logic [63:0] acc_rdata;
    logic [3:0]  chg_table, win_index;
    logic [8:0]  chg_index;
    logic [2:0]  irq_cfg_index;
    logic [5:0]  irq_server;
    logic [7:0]  irq_prio;

    always #5 clk = ~clk;

    table_access_port uut (
        .clk, .rst, .acc_valid, .acc_write, .acc_data_sel, .acc_wdata,
        .acc_rvalid, .acc_rdata, .acc_err, .chg_valid, .chg_table, .chg_index,
        .win_update, .win_index, .irq_cfg_valid, .irq_cfg_index, .irq_server, .irq_prio
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] maddr;
    logic [63:0] mdl [0:1023];

    function automatic logic [8:0] f_mask(input logic [3:0] s);
        case (s)
            4'd0, 4'd1, 4'd5:   return 9'd7;
            4'd2, 4'd3:         return 9'd31;
            4'd4, 4'd9, 4'd10:  return 9'd63;
            4'd6, 4'd7, 4'd12:  return 9'd255;
            4'd8:               return 9'd511;
            4'd11:              return 9'd15;
            4'd13:              return 9'd3;
            default:            return 9'd0;
        endcase
    endfunction

    function automatic bit f_known(input logic [3:0] s);
        return s <= 4'd13;
    endfunction

    function automatic bit f_backed(input logic [3:0] s);
        return (s == 0) || (s == 1) || (s == 8) || (s == 11) || (s == 12) || (s == 13);
    endfunction

    function automatic int f_base(input logic [3:0] s);
        case (s)
            4'd0:    return 0;
            4'd1:    return 8;
            4'd11:   return 16;
            4'd13:   return 32;
            4'd12:   return 256;
            default: return 512;
        endcase
    endfunction

    function automatic logic [63:0] f_addr(input bit ai, input logic [3:0] s, input logic [8:0] ix);
        logic [63:0] a;
        a = '0;
        a[63] = ai;
        a[51:48] = s;
        a[8:0] = ix;
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input bit ds, input logic [63:0] d);
        logic [3:0]  s;
        logic [8:0]  ix;
        logic [63:0] er, st;
        bit kn, bk, ai, ec, ew, ei;
        s  = maddr[51:48];
        ix = maddr[8:0] & f_mask(s);
        kn = f_known(s);
        bk = f_backed(s);
        ai = maddr[63];
        er = ds ? ((kn && bk) ? mdl[f_base(s) + int'(ix)] : 64'd0) : maddr;
        st = (s == 4'd1) ? (d & 64'h0000_0000_FFFF_000F) : d;
        ec = ds && wr && kn;
        ew = ec && (s == 4'd11);
        ei = ec && (s == 4'd1);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_data_sel = ds; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(acc_rvalid == !wr, "R10 read valid", 64'(acc_rvalid), 64'(!wr));
        if (!wr)
            chk(acc_rdata == er, !ds ? "R1 address readback" :
                (!kn ? "R5 unknown read zero" : (bk ? "R11 stored read" : "R4 unbacked read zero")),
                acc_rdata, er);
        if (ds) chk(acc_err == !kn, "R5 error pulse", 64'(acc_err), 64'(!kn));
        chk(chg_valid == ec, "R9 change pulse", 64'(chg_valid), 64'(ec));
        if (ec) chk({chg_table, chg_index} == {s, ix}, "R9 R2 change table/index",
                    64'({chg_table, chg_index}), 64'({s, ix}));
        chk(win_update == ew, "R8 window pulse", 64'(win_update), 64'(ew));
        if (ew) chk(win_index == ix[3:0], "R8 window index", 64'(win_index), 64'(ix[3:0]));
        chk(irq_cfg_valid == ei, "R7 vector pulse", 64'(irq_cfg_valid), 64'(ei));
        if (ei) chk({irq_cfg_index, irq_server, irq_prio} == {ix[2:0], d[31:26], d[23:16]},
                    "R7 vector fields", 64'({irq_cfg_index, irq_server, irq_prio}),
                    64'({ix[2:0], d[31:26], d[23:16]}));
        if (!ds && wr) begin
            maddr = d;
        end else if (ds && kn) begin
            if (wr && bk) mdl[f_base(s) + int'(ix)] = st;
            if (ai) maddr[8:0] = (ix + 9'd1) & f_mask(s);
        end
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_data_sel = 1'b0; acc_wdata = '0;
        maddr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!acc_rvalid && !acc_err && !chg_valid && !win_update && !irq_cfg_valid,
            "R1 reset outputs", 64'({acc_rvalid, acc_err, chg_valid}), 64'd0);
        acc(0, 0, 64'd0);

        // fill every backed table with stepping writes; index must wrap back to 0
        foreach (seed_list[k]) begin
            acc(1, 0, f_addr(1, seed_list[k], 9'd0));
            for (int i = 0; i <= int'(f_mask(seed_list[k])); i++) acc(1, 1, rnd64());
            acc(0, 0, 64'd0); // R3 wrap to zero
        end

        // R6 R7: vector write of all ones, read back filtered, no step
        acc(1, 0, f_addr(0, 4'd1, 9'd5));
        acc(1, 1, '1);
        acc(0, 1, 64'd0);
        acc(0, 0, 64'd0);

        // R2: raw index 0x1FE on the 4-entry table
        acc(1, 0, f_addr(1, 4'd13, 9'h1FE));
        acc(0, 1, 64'd0);
        acc(0, 1, 64'd0);
        acc(0, 1, 64'd0);
        acc(0, 0, 64'd0);

        // R4: storage-less table still steps
        acc(1, 0, f_addr(1, 4'd5, 9'd7));
        acc(1, 1, rnd64());
        acc(0, 0, 64'd0);
        acc(0, 1, 64'd0);
        acc(0, 0, 64'd0);

        // R5: unknown selects
        acc(1, 0, f_addr(1, 4'd14, 9'd3) | 64'h0000_00F0_0000_0000);
        acc(0, 1, 64'd0);
        acc(1, 1, rnd64());
        acc(0, 0, 64'd0);
        acc(1, 0, f_addr(1, 4'd15, 9'd0));
        acc(1, 1, rnd64());
        acc(0, 0, 64'd0);

        // R8: last window entry wraps
        acc(1, 0, f_addr(1, 4'd11, 9'd15));
        acc(1, 1, rnd64());
        acc(0, 0, 64'd0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned op;
            op = $urandom % 8;
            if (op == 0) begin
                logic [63:0] a;
                a = rnd64();
                a[51:48] = 4'($urandom % 16);
                acc(1, 0, a);
            end else if (op == 1) begin
                acc(0, 0, 64'd0);
            end else if (op < 5) begin
                acc(0, 1, 64'd0);
            end else begin
                acc(1, 1, rnd64());
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    logic [3:0] seed_list [6] = '{4'd0, 4'd1, 4'd11, 4'd13, 4'd12, 4'd8};

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule